// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is a configurable two-level logic array. Every dedicated input and every fed-back output line enters the array twice: once as its true value and once as its complement. Each product term is a wide AND whose inputs are picked from this literal set by configuration bits. The OR side is wired in fixed groups. Each output owns a group of product terms. The first term of each group drives that output's enable, and the remaining terms are ORed into its logic result.

The configuration is held in flip-flops. It is written one product-term row per clock through a parallel write port while the write strobe is high. From pins, feedback and stored configuration to the outputs, the path is purely combinational. Output registers, polarity control and pad drivers sit outside the block. The surrounding logic returns the outputs on the feedback bus.

Top module: `sop_logic_plane`

## Requirements
- R1: While `rst_n` is low, all configuration bits are cleared. Every term is therefore empty, so `sum_out` and `oe_out` read all ones.
- R2: On a rising `clk` edge with `cfg_we` high, row `cfg_row` takes the value of `cfg_bits`. Row index = output × 8 + term.
- R3: On an edge with `cfg_we` low, the configuration does not change.
- R4: Literal layout within a row: bit 2k is the true form of signal k, and bit 2k+1 is its complement. Signals 0–9 are `pin_in[0..9]` and signals 10–17 are `fb_in[0..7]`.
- R5: A term is the AND of its connected literals. A term with no connected literal evaluates to 1.
- R6: A term that connects both the true and the complement form of any one signal evaluates to 0.
- R7: Term 0 of output j drives `oe_out[j]` only and has no effect on `sum_out[j]`.
- R8: `sum_out[j]` is the OR of terms 1–7 of output j. Terms belonging to other outputs have no effect on it.
- R9: Outputs follow changes on `pin_in` and `fb_in` without waiting for a clock edge.
- R10: Feedback literals act in terms exactly like pin literals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_we | input | 1 | Configuration row write strobe |
| cfg_row | input | 6 | Row to write (output × 8 + term) |
| cfg_bits | input | 36 | Literal connection bits for the row |
| pin_in | input | 10 | Dedicated array inputs |
| fb_in | input | 8 | Fed-back output lines |
| sum_out | output | 8 | Sum-of-products result per output |
| oe_out | output | 8 | Enable term per output |

## Verification
The hardest condition to reach from the ports is proof that grouping and literal placement are exact. A wrong row or bit offset can still produce plausible outputs for many inputs. To expose such faults, the stimulus programs one output with pin literals in both polarities and another with feedback literals. Every other term is forced off by a contradiction. A vector table then walks patterns in which exactly one literal decides each output. Pairs of vectors that differ only in the enable-term input show that this input leaves the sum unchanged. A later row rewrite switches one term to empty and confirms that only the targeted output changes.

// File: rtl/sop_logic_plane.sv
module sop_logic_plane #(
  parameter int N_IN  = 10,
  parameter int N_OUT = 8,
  parameter int N_PT  = 8,
  localparam int N_SIG  = N_IN + N_OUT,
  localparam int N_LIT  = 2 * N_SIG,
  localparam int N_ROWS = N_OUT * N_PT,
  localparam int ROW_W  = $clog2(N_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic [N_LIT-1:0] cfg_bits,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] fb_in,
  output logic [N_OUT-1:0] sum_out,
  output logic [N_OUT-1:0] oe_out
);

  localparam logic [N_LIT-1:0] TRUE_MASK = {N_SIG{2'b01}};

  logic [N_ROWS-1:0][N_LIT-1:0] cfg_q;
  logic [N_SIG-1:0]  sig;
  logic [N_LIT-1:0]  lit;
  logic [N_ROWS-1:0] term;

  assign sig = {fb_in, pin_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q[cfg_row] <= cfg_bits;
  end

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[2*s]   = sig[s];
    assign lit[2*s+1] = ~sig[s];
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_term
    assign term[r] = &(lit | ~cfg_q[r]);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign oe_out[j]  = term[j*N_PT];
    assign sum_out[j] = |term[j*N_PT+1 +: N_PT-1];

    // R5
    empty_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[j*N_PT] == '0) |-> oe_out[j]);

    // R6
    clash_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(cfg_q[j*N_PT] & (cfg_q[j*N_PT] >> 1) & TRUE_MASK)) |-> !oe_out[j]);
  end

  // R2
  row_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q[$past(cfg_row)] == $past(cfg_bits));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

  // R9
  comb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pin_in) && $stable(fb_in) && $stable(cfg_q))
      |-> ($stable(sum_out) && $stable(oe_out)));

endmodule

// File: tb/test_sop_logic_plane.sv
module test_sop_logic_plane;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_row = '0;
  logic [35:0] cfg_bits = '0;
  logic [9:0]  pin_in = '0;
  logic [7:0]  fb_in = '0;
  logic [7:0]  sum_out, oe_out;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sop_logic_plane i_sop_logic_plane (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_bits(cfg_bits), .pin_in(pin_in), .fb_in(fb_in),
    .sum_out(sum_out), .oe_out(oe_out)
  );

  // {pin_in, fb_in, expected sum_out, expected oe_out}
  // out0: oe = p0, sum = p1&p2 | ~p3 ; out1: oe = 1, sum = f0 | ~f7&p9 ; others off
  localparam logic [33:0] VEC [9] = '{
    {10'h000, 8'h00, 8'h01, 8'h02},
    {10'h001, 8'h00, 8'h01, 8'h03},
    {10'h008, 8'h00, 8'h00, 8'h02},
    {10'h00E, 8'h00, 8'h01, 8'h02},
    {10'h200, 8'h00, 8'h03, 8'h02},
    {10'h208, 8'h80, 8'h00, 8'h02},
    {10'h009, 8'h01, 8'h02, 8'h03},
    {10'h3FF, 8'hFF, 8'h03, 8'h03},
    {10'h00C, 8'h7E, 8'h00, 8'h02}
  };

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int row, logic [35:0] bits);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = row[5:0]; cfg_bits = bits;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 R5: cleared configuration gives empty terms
    chk("R1 sum after reset", sum_out, 8'hFF);
    chk("R1 oe after reset", oe_out, 8'hFF);
    rst_n = 1'b1;

    // R3: write data presented without strobe
    @(negedge clk);
    cfg_row = 6'd0; cfg_bits = 36'h3;
    @(negedge clk);
    @(negedge clk);
    chk("R3 oe with strobe low", oe_out, 8'hFF);
    chk("R3 sum with strobe low", sum_out, 8'hFF);

    // R2 R4: program the array
    for (int r = 0; r < 64; r++) begin
      logic [35:0] b;
      case (r)
        0:  b = 36'h000000001;
        1:  b = 36'h000000014;
        2:  b = 36'h000000080;
        8:  b = 36'h000000000;
        9:  b = 36'h000100000;
        10: b = 36'h800040000;
        default: b = 36'h000000003;
      endcase
      wr(r, b);
    end

    // R4 R5 R6 R7 R8 R10: table walk
    for (int v = 0; v < 9; v++) begin
      @(negedge clk);
      pin_in = VEC[v][33:24];
      fb_in  = VEC[v][23:16];
      #1;
      chk($sformatf("R8 R10 sum vec %0d", v), sum_out, VEC[v][15:8]);
      chk($sformatf("R7 R6 oe vec %0d", v), oe_out, VEC[v][7:0]);
    end

    // R9: change inputs mid-cycle, no clock edge between
    @(negedge clk);
    pin_in = 10'h000; fb_in = 8'h00;
    #1 chk("R9 sum before change", sum_out, 8'h01);
    pin_in = 10'h008;
    #1 chk("R9 sum follows input", sum_out, 8'h00);
    fb_in = 8'h01;
    #1 chk("R9 R10 sum follows feedback", sum_out, 8'h02);

    // R2 R5: rewrite out1 term1 to empty -> sum1 always 1
    pin_in = 10'h000; fb_in = 8'h00;
    wr(9, 36'h0);
    #1;
    chk("R2 R5 sum after rewrite", sum_out, 8'h03);
    chk("R8 oe untouched by rewrite", oe_out, 8'h02);

    // R1: reset again clears everything
    rst_n = 1'b0;
    #1;
    chk("R1 sum after second reset", sum_out, 8'hFF);
    chk("R1 oe after second reset", oe_out, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule